// File: doc/BRIEF.md
# Scan-Chain Test Wrapper for a Two-Bit Mealy Machine

This block wraps a small synchronous Mealy machine, with one primary input `w`, two state flip-flops (y1, y2) and one output `z`, so that it can be tested through a serial scan chain. A 2:1 multiplexer sits in front of every chain flip-flop. It selects either the functional next value or the previous chain element. In shift mode the flip-flops form a shift register that runs from `scanIn` to `scanOut`. When the parameter `SCAN_INPUT` is 1, an extra flip-flop that samples `w` is placed at the head of the chain. That flip-flop lets a test vector set the input the machine sees as well as its state.

A one-cycle `start` strobe launches a fixed sequence that a built-in controller runs without further help. The sequence shifts a vector in, applies one capture clock in normal mode, shifts the captured contents out, and then raises `done` for one cycle. During the capture cycle, `z` is observed directly at its pin and not through the chain. While the controller is idle, `scanEnable` lets an external tester shift the chain by hand. When `scanEnable` is low the machine runs functionally.

Top module: `scan_test_wrapper`

## Requirements
- R1: After a synchronous active-high reset, every chain flip-flop is 0, `scanOut` is 0, `done` is 0 and the controller is idle.
- R2: When the controller is idle and `scanEnable` is low, the machine updates once per clock: y1 becomes w&(y1|y2), y2 becomes w&~y1&~y2, the w flip-flop samples the `w` pin, and `z` equals w&y1, where w is the pin value.
- R3: When the controller is idle and `scanEnable` is high, each clock shifts the chain by one place and the functional update does not happen. The chain order is `scanIn` → w flip-flop → y1 → y2 → `scanOut`, and `scanOut` always shows y2.
- R4: A `start` pulse while idle causes exactly 3 shift clocks (one per chain element) that take their bits from `scanIn`. The bit shifted in first ends up in y2, the second in y1 and the third in the w flip-flop.
- R5: Exactly one capture cycle follows the shift-in. During it, `z` and the next state are computed from the scanned-in w bit, not from the `w` pin, and the next state is loaded into y1 and y2 at the end of the cycle.
- R6: During the capture clock, the w flip-flop samples the `w` pin. For the following 3 cycles `scanOut` shows the captured y2, then y1, then that sampled w.
- R7: `done` is high for exactly one cycle, immediately after the last shift-out clock. The controller is then idle again and `done` stays low.
- R8: While a sequence is running, `start` and `scanEnable` have no effect on the shifted data, on the capture or on the timing of `done`.
- R9: The vector (w, y1, y2) = (0, 0, 1) gives `z` = 0 during capture and a captured next state of y1 = 0, y2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the shift-in, capture, shift-out sequence (used only while idle) |
| scanEnable | input | 1 | Manual shift while idle; suppresses the functional update |
| scanIn | input | 1 | Serial chain input |
| w | input | 1 | Primary input of the Mealy machine |
| scanOut | output | 1 | Serial chain output (last chain element, y2) |
| z | output | 1 | Mealy output |
| done | output | 1 | One-cycle pulse at the end of a test sequence |

## Verification
The bench builds the block with the default `SCAN_INPUT` = 1, which gives a three-element chain. With that setting the scanned w bit can be set to the opposite of the `w` pin during capture, so the bench can tell whether the input was taken from the chain or from the pin. Random vectors cover all eight (w, y1, y2) combinations, and the directed runs add the stated example vector and functional stretches that are read back by manual shifting. Start and scan-enable pulses are also injected in the middle of a sequence to check that they are ignored.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;
  // Number of state flip-flops in the wrapped Mealy machine.
  localparam int STATE_W = 2;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic shiftEn;    // chain shifts one place
    logic captureEn;  // one normal-mode clock for the test
    logic funcEn;     // ordinary functional update
  } chainCtl_t;

  typedef enum logic [2:0] {
    CtlIdle   = 3'd0,
    CtlLoad   = 3'd1,
    CtlCapt   = 3'd2,
    CtlUnload = 3'd3,
    CtlFin    = 3'd4
  } ctlState_t;
endpackage

// File: rtl/mealy_logic.sv
module mealy_logic
  import scan_wrap_pkg::*;
(
  input  logic               wEff,
  input  logic [STATE_W-1:0] curState,  // [0]=y1, [1]=y2
  output logic [STATE_W-1:0] nxtState,
  output logic               zOut
);
  logic y1, y2;

  always_comb begin
    y1 = curState[0];
    y2 = curState[1];
    nxtState[0] = wEff & (y1 | y2);
    nxtState[1] = wEff & ~y1 & ~y2;
    zOut        = wEff & y1;
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_wrap_pkg::*;
#(
  parameter int CHAIN_LEN = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      scanEnable,
  output chainCtl_t ctl,
  output logic      done
);
  localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHAIN_LEN - 1);

  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      CtlIdle: begin
        cntNext = '0;
        if (start) stateNext = CtlLoad;
      end
      CtlLoad: begin
        if (cnt == LAST_CNT) begin
          stateNext = CtlCapt;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      CtlCapt: stateNext = CtlUnload;
      CtlUnload: begin
        if (cnt == LAST_CNT) begin
          stateNext = CtlFin;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      CtlFin:  stateNext = CtlIdle;
      default: stateNext = CtlIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CtlIdle;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    ctl.shiftEn   = (state == CtlLoad) || (state == CtlUnload) ||
                    ((state == CtlIdle) && scanEnable);
    ctl.captureEn = (state == CtlCapt);
    ctl.funcEn    = (state == CtlIdle) && !scanEnable;
  end

  assign done = (state == CtlFin);

  // R7: done lasts one cycle and is followed by idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && state == CtlIdle));

  // R5: the capture cycle is a single cycle and is followed by shift-out
  p_single_capture_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.captureEn |=> (!ctl.captureEn && ctl.shiftEn));

  // R4: start from idle enters shift-in with the counter at zero
  p_start_load_r4: assert property (@(posedge clk) disable iff (rst)
    (state == CtlIdle && start) |=> (state == CtlLoad && cnt == '0));

  // R8: start is ignored while a sequence is running
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (state == CtlLoad && cnt != LAST_CNT) |=> (state == CtlLoad));

  // R4: the shift counter never passes the chain length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state == CtlLoad || state == CtlUnload) |-> (cnt <= LAST_CNT));

  // at most one strobe per cycle
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.shiftEn, ctl.captureEn, ctl.funcEn}));
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_wrap_pkg::*;
#(
  parameter int SCAN_INPUT = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  chainCtl_t ctl,
  input  logic      scanIn,
  input  logic      wPin,
  output logic      scanOut,
  output logic      z
);
  localparam int LEN = STATE_W + SCAN_INPUT;

  logic [LEN-1:0]     chain, chainNext, shiftVec, loadVec;
  logic [STATE_W-1:0] curState, nxtState;
  logic               wEff;

  assign curState = chain[SCAN_INPUT +: STATE_W];

  // mux-D chain: each element either takes its left neighbour or the functional value
  for (genvar i = 0; i < LEN; i++) begin : g_shift
    if (i == 0) begin : g_head
      assign shiftVec[i] = scanIn;
    end else begin : g_body
      assign shiftVec[i] = chain[i-1];
    end
  end

  if (SCAN_INPUT != 0) begin : g_w_in_chain
    assign wEff    = ctl.captureEn ? chain[0] : wPin;
    assign loadVec = {nxtState, wPin};
  end else begin : g_w_direct
    assign wEff    = wPin;
    assign loadVec = nxtState;
  end

  mealy_logic u_logic (
    .wEff    (wEff),
    .curState(curState),
    .nxtState(nxtState),
    .zOut    (z)
  );

  always_comb begin
    chainNext = chain;
    if (ctl.shiftEn)                       chainNext = shiftVec;
    else if (ctl.captureEn || ctl.funcEn)  chainNext = loadVec;
  end

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= chainNext;
  end

  assign scanOut = chain[LEN-1];

  // R3: in shift mode the head takes scanIn and the tail takes its neighbour
  p_head_shift_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEn |=> (chain[0] == $past(scanIn)));

  p_tail_shift_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEn |=> (scanOut == $past(chain[LEN-2])));

  // R8: with no strobe the chain holds its contents
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(ctl.shiftEn || ctl.captureEn || ctl.funcEn) |=> $stable(chain));

  // R5: capture loads the next state that was computed from the chain's w bit
  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.captureEn |=> (curState == $past(nxtState)));
endmodule

// File: rtl/scan_test_wrapper.sv
module scan_test_wrapper
  import scan_wrap_pkg::*;
#(
  parameter int SCAN_INPUT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic scanEnable,
  input  logic scanIn,
  input  logic w,
  output logic scanOut,
  output logic z,
  output logic done
);
  localparam int CHAIN_LEN = STATE_W + SCAN_INPUT;

  chainCtl_t ctl;

  scan_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .scanEnable(scanEnable),
    .ctl       (ctl),
    .done      (done)
  );

  scan_datapath #(.SCAN_INPUT(SCAN_INPUT)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .scanIn (scanIn),
    .wPin   (w),
    .scanOut(scanOut),
    .z      (z)
  );
endmodule

// File: tb/test_scan_test_wrapper.sv
module test_scan_test_wrapper;
  logic clk = 1'b0;
  logic rst, start, scanEnable, scanIn, w;
  logic scanOut, z, done;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  scan_test_wrapper i_scan_test_wrapper (
    .clk(clk), .rst(rst), .start(start), .scanEnable(scanEnable),
    .scanIn(scanIn), .w(w), .scanOut(scanOut), .z(z), .done(done)
  );

  function automatic logic fnY1(logic wi, logic a, logic b); return wi & (a | b); endfunction
  function automatic logic fnY2(logic wi, logic a, logic b); return wi & ~a & ~b; endfunction
  function automatic logic fnZ(logic wi, logic a);           return wi & a;        endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Complete sequence: vector (vw, v1, v2), w pin value pw during capture; noisy injects start/scanEnable
  task automatic runSeq(input logic vw, input logic v1, input logic v2,
                        input logic pw, input bit noisy, input string tag);
    logic eY1, eY2, eZ;
    logic [2:0] bits;
    eY1 = fnY1(vw, v1, v2);
    eY2 = fnY2(vw, v1, v2);
    eZ  = fnZ(vw, v1);
    bits = {vw, v1, v2};
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      scanIn = bits[i];          // y2 first, then y1, then w
      if (noisy && i == 1) begin start = 1'b1; scanEnable = 1'b1; end
      #1;
      chk(done == 1'b0, {tag, " R7 done low in shift-in"}, done, 0);
      tick();
      start = 1'b0;
      scanEnable = 1'b0;
    end
    // capture cycle
    w = pw;
    if (noisy) begin start = 1'b1; scanEnable = 1'b1; end
    #1;
    chk(z == eZ, {tag, " R5 z from scanned w"}, z, eZ);
    chk(scanOut == v2, {tag, " R4 first bit in y2"}, scanOut, v2);
    tick();
    start = 1'b0;
    scanEnable = 1'b0;
    w = ~pw;
    chk(scanOut == eY2, {tag, " R6 captured y2"}, scanOut, eY2);
    tick();
    chk(scanOut == eY1, {tag, " R6 captured y1"}, scanOut, eY1);
    tick();
    chk(scanOut == pw, {tag, " R6 sampled w pin"}, scanOut, pw);
    chk(done == 1'b0, {tag, " R7 done not early"}, done, 0);
    tick();
    chk(done == 1'b1, {tag, " R7 done pulse"}, done, 1);
    scanEnable = 1'b1;           // hold chain in shift mode so idle state is inert
    tick();
    chk(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
    tick();
    chk(done == 1'b0, {tag, " R8 no restart"}, done, 0);
    scanEnable = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic sy1, sy2, lastW;
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; scanEnable = 1'b0; scanIn = 1'b0; w = 1'b0;
    tick(); tick();
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(scanOut == 1'b0, "R1 scanOut after reset", scanOut, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    // chain contents read by manual shift: all zero
    scanEnable = 1'b1; scanIn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk(scanOut == 1'b0, "R1 chain cleared", scanOut, 0);
      tick();
    end
    // R3: the ones shifted in now reach scanOut, functional update suppressed
    w = 1'b1;
    chk(scanOut == 1'b1, "R3 shifted one arrives", scanOut, 1);
    scanEnable = 1'b0; scanIn = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;

    // R2: functional mode with random w, read back by manual shift (R3)
    for (int run = 0; run < 6; run++) begin
      sy1 = 1'b0; sy2 = 1'b0; lastW = 1'b0;
      for (int c = 0; c < 8; c++) begin
        w = 1'($urandom);
        #1;
        chk(z == fnZ(w, sy1), "R2 functional z", z, fnZ(w, sy1));
        {sy1, sy2} = {fnY1(w, sy1, sy2), fnY2(w, sy1, sy2)};
        lastW = w;
        tick();
      end
      scanEnable = 1'b1;
      w = ~lastW;
      chk(scanOut == sy2, "R3 read y2", scanOut, sy2);
      tick();
      chk(scanOut == sy1, "R3 read y1", scanOut, sy1);
      tick();
      chk(scanOut == lastW, "R3 read w cell", scanOut, lastW);
      scanEnable = 1'b0;
      rst = 1'b1; tick(); rst = 1'b0;
    end

    // R9: the stated example vector
    runSeq(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    // directed corners with pin opposite to scanned w
    runSeq(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 w1s00");
    runSeq(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 w1s10");
    // R8: injected start/scanEnable during a running sequence
    runSeq(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R8 noisy");
    runSeq(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R8 noisy2");
    // random vectors
    for (int k = 0; k < 40; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      runSeq(r[0], r[1], r[2], r[3], 1'($urandom), "R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule